// File: doc/BRIEF.md
# Load/Store Byte Lane Aligner

This block sits between a core's datapath and a data memory port that is one word wide and addressed by word. Each request carries the operation, the access size, a signed flag, an endianness select, and the low bits of the byte address. A request also carries three words: the word read from memory, the data to be stored, and the current value of the destination register.

For a load, the block picks the addressed bytes out of the memory word. It orders them for the chosen endianness and then sign-extends or zero-extends the result. For a store, it produces a per-lane write mask and moves the store value onto the lanes that the mask enables.

Halfword and word requests that are not naturally aligned are not carried out. Instead they raise a misalignment flag. Two partial-load operations, head and tail, each merge some bytes into the old register value. Issued in that order at the same unaligned address, with the memory word at that address and then the following word, they build the complete unaligned word. Requests enter on a valid/ready input. Results leave on a valid/ready output. When the `PIPE` parameter is 1, a single register stage separates the two sides.

Top module: `lsu_lane_align`

## Requirements
- R1: Little-endian mode (`req_big_endian`=0): the byte at address offset o lives in lane o, bits [8o+7:8o]. A multi-byte value has its least significant byte at the lowest address.
- R2: Big-endian mode (`req_big_endian`=1): the byte at offset o lives in lane LANES-1-o, and the most significant byte sits at the lowest address. An aligned word load returns the memory word unchanged in both modes.
- R3: Operation codes are 00 load, 01 store, 10 head, 11 tail. Size codes are 00 byte, 01 halfword, 10 or 11 word. A byte or halfword load fills the upper result bytes with copies of its top bit when `req_signed`=1, and with zeros when `req_signed`=0.
- R4: A halfword load or store with offset bit 0 set is misaligned. So is a word load or store with a non-zero offset. Such a request sets `rsp_misalign`, and its load data, store data and write mask are all zero. Byte accesses and partial loads are never flagged.
- R5: A store sets exactly those mask bits whose lanes receive a stored byte. Load-type operations return a zero mask and zero store data.
- R6: The store value's low bytes are placed on the enabled lanes in the order given by R1/R2. Lanes that are not enabled carry zero.
- R7: A head load at offset o takes bytes o through LANES-1 of the memory word as the first part of the assembled value. The remaining register bytes keep their old value. With offset 0, the whole word is replaced.
- R8: A tail load at offset o takes bytes 0 through o-1 of the memory word as the last o bytes of the assembled value. The other register bytes keep their old value. With offset 0, the register value is left unchanged.
- R9: With `PIPE`=1, a request accepted at a clock edge appears on the output after that edge. `req_ready` is high whenever the output is empty or being consumed. While `rsp_valid` is high and `rsp_ready` is low, the output stays unchanged.
- R10: While reset is asserted, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_op | input | 2 | Operation code (R3) |
| req_size | input | 2 | Access size code (R3) |
| req_signed | input | 1 | Sign-extend loads |
| req_big_endian | input | 1 | Lane order select |
| req_offset | input | $clog2(LANES) | Low bits of the byte address |
| req_wdata | input | 8*LANES | Store value, right-aligned |
| req_rdata | input | 8*LANES | Word read from memory |
| req_old | input | 8*LANES | Current destination register value |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumed this cycle |
| rsp_ld_data | output | 8*LANES | Load or merged result |
| rsp_st_data | output | 8*LANES | Store data on memory lanes |
| rsp_be | output | LANES | Per-lane write enable |
| rsp_misalign | output | 1 | Misaligned request flag |

## Verification
The bench builds the block with LANES=4 and PIPE=1. Four lanes are enough to reach every offset of both partial loads in both lane orders, including the offsets at which a whole word or nothing is merged. Enabling the register stage brings the one-cycle latency and the back-pressure hold within reach, so the bench can stall the output and show that a waiting result does not change while new requests are refused.

// File: rtl/lsu_lane_pkg.sv
`timescale 1ns/1ps
package lsu_lane_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_HEAD  = 2'b10,
    OP_TAIL  = 2'b11
  } lane_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } lane_size_e;

  // Bytes moved by an access of the given size code.
  function automatic int size_bytes(input logic [1:0] sz, input int lanes);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return lanes;
    endcase
  endfunction

  // Natural alignment test: offset must be a multiple of the access size.
  function automatic logic misaligned(input logic [1:0] sz, input int off);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return (off % 2) != 0;
      default: return off != 0;
    endcase
  endfunction

endpackage

// File: rtl/lsu_lane_load.sv
`timescale 1ns/1ps
module lsu_lane_load
  import lsu_lane_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DW    = 8 * LANES,
  localparam int OFS_W = $clog2(LANES)
) (
  input  lane_op_e           op,
  input  logic [1:0]         size,
  input  logic               sgn,
  input  logic               big_end,
  input  logic [OFS_W-1:0]   off,
  input  logic [DW-1:0]      mem_word,
  input  logic [DW-1:0]      old_val,
  output logic [DW-1:0]      result
);

  // Memory bytes re-indexed by address offset.
  logic [7:0] abyte [LANES];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      abyte[i] = big_end ? mem_word[8*(LANES-1-i) +: 8] : mem_word[8*i +: 8];
    end
  end

  always_comb begin
    int n;
    logic fill;
    logic [OFS_W-1:0] src;
    n      = size_bytes(size, LANES);
    fill   = 1'b0;
    result = '0;
    if (op == OP_HEAD || op == OP_TAIL) begin
      result = old_val;
      for (int j = 0; j < LANES; j++) begin
        src = off + OFS_W'(j);
        if ((op == OP_HEAD) == ((int'(off) + j) < LANES)) begin
          if (big_end) result[8*(LANES-1-j) +: 8] = abyte[src];
          else         result[8*j +: 8]           = abyte[src];
        end
      end
    end else begin
      for (int j = 0; j < LANES; j++) begin
        src = off + OFS_W'(j);
        for (int k = 0; k < LANES; k++) begin
          if (j < n && k == (big_end ? n - 1 - j : j)) result[8*k +: 8] = abyte[src];
        end
      end
      for (int k = 0; k < LANES; k++) begin
        if (k == n - 1) fill = sgn & result[8*k + 7];
      end
      for (int k = 0; k < LANES; k++) begin
        if (k >= n) result[8*k +: 8] = {8{fill}};
      end
    end
  end

endmodule

// File: rtl/lsu_lane_store.sv
`timescale 1ns/1ps
module lsu_lane_store
  import lsu_lane_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DW    = 8 * LANES,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic               en,
  input  logic [1:0]         size,
  input  logic               big_end,
  input  logic [OFS_W-1:0]   off,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      st_data,
  output logic [LANES-1:0]   st_be
);

  // vseq[j] is the byte written at address offset off+j.
  logic [7:0] vseq [LANES];

  always_comb begin
    int n;
    n = size_bytes(size, LANES);
    for (int j = 0; j < LANES; j++) begin
      vseq[j] = '0;
      for (int v = 0; v < LANES; v++) begin
        if (j < n && v == (big_end ? n - 1 - j : j)) vseq[j] = wdata[8*v +: 8];
      end
    end
  end

  always_comb begin
    int n;
    int ai;
    n       = size_bytes(size, LANES);
    st_data = '0;
    st_be   = '0;
    for (int l = 0; l < LANES; l++) begin
      ai = big_end ? LANES - 1 - l : l;
      for (int j = 0; j < LANES; j++) begin
        if (en && j < n && (int'(off) + j) == ai) begin
          st_data[8*l +: 8] = vseq[j];
          st_be[l]          = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lsu_lane_stage.sv
`timescale 1ns/1ps
module lsu_lane_stage #(
  parameter int W    = 8,
  parameter bit PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  if (PIPE) begin : g_reg
    logic         vld_q;
    logic [W-1:0] dat_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        dat_q <= in_data;
      end
    end

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_data  = dat_q;
  end else begin : g_wire
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end

endmodule

// File: rtl/lsu_lane_align.sv
`timescale 1ns/1ps
module lsu_lane_align
  import lsu_lane_pkg::*;
#(
  parameter int LANES = 4,
  parameter bit PIPE  = 1'b1,
  localparam int DW    = 8 * LANES,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic [1:0]         req_size,
  input  logic               req_signed,
  input  logic               req_big_endian,
  input  logic [OFS_W-1:0]   req_offset,
  input  logic [DW-1:0]      req_wdata,
  input  logic [DW-1:0]      req_rdata,
  input  logic [DW-1:0]      req_old,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DW-1:0]      rsp_ld_data,
  output logic [DW-1:0]      rsp_st_data,
  output logic [LANES-1:0]   rsp_be,
  output logic               rsp_misalign
);

  localparam int PW = 2 * DW + LANES + 1;

  lane_op_e         op;
  logic             mis;
  logic [DW-1:0]    load_res;
  logic [DW-1:0]    ld_data;
  logic [DW-1:0]    st_data;
  logic [LANES-1:0] st_be;
  logic [PW-1:0]    pay_in;
  logic [PW-1:0]    pay_out;

  assign op  = lane_op_e'(req_op);
  assign mis = (op == OP_LOAD || op == OP_STORE) && misaligned(req_size, int'(req_offset));

  lsu_lane_load #(.LANES(LANES)) u_load (
    .op       (op),
    .size     (req_size),
    .sgn      (req_signed),
    .big_end  (req_big_endian),
    .off      (req_offset),
    .mem_word (req_rdata),
    .old_val  (req_old),
    .result   (load_res)
  );

  lsu_lane_store #(.LANES(LANES)) u_store (
    .en       (op == OP_STORE && !mis),
    .size     (req_size),
    .big_end  (req_big_endian),
    .off      (req_offset),
    .wdata    (req_wdata),
    .st_data  (st_data),
    .st_be    (st_be)
  );

  assign ld_data = (op != OP_STORE && !mis) ? load_res : '0;
  assign pay_in  = {ld_data, st_data, st_be, mis};

  lsu_lane_stage #(.W(PW), .PIPE(PIPE)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (pay_in),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (pay_out)
  );

  assign {rsp_ld_data, rsp_st_data, rsp_be, rsp_misalign} = pay_out;

endmodule

// File: rtl/lsu_lane_align_chk.sv
`timescale 1ns/1ps
module lsu_lane_align_chk #(
  parameter int LANES = 4,
  parameter bit PIPE  = 1'b1,
  localparam int DW   = 8 * LANES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [DW-1:0]    rsp_ld_data,
  input logic [DW-1:0]    rsp_st_data,
  input logic [LANES-1:0] rsp_be,
  input logic             rsp_misalign
);

  logic [DW-1:0] lane_mask;

  always_comb begin
    for (int l = 0; l < LANES; l++) lane_mask[8*l +: 8] = {8{rsp_be[l]}};
  end

  // R4
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_misalign |-> rsp_be == '0 && rsp_ld_data == '0 && rsp_st_data == '0);

  // R5
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_be) == 0 || $countones(rsp_be) == 1 ||
                   $countones(rsp_be) == 2 || $countones(rsp_be) == LANES));

  // R6
  idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_st_data & ~lane_mask) == '0);

  if (PIPE) begin : g_pipe_chk
    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ld_data) &&
        $stable(rsp_st_data) && $stable(rsp_be) && $stable(rsp_misalign));

    // R9
    empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> req_ready);
  end

endmodule

bind lsu_lane_align lsu_lane_align_chk #(.LANES(LANES), .PIPE(PIPE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_ld_data  (rsp_ld_data),
  .rsp_st_data  (rsp_st_data),
  .rsp_be       (rsp_be),
  .rsp_misalign (rsp_misalign)
);

// File: tb/sim_lsu_lane_align.sv
`timescale 1ns/1ps
module sim_lsu_lane_align;

  localparam logic [31:0] MW = 32'hA1B2_C3D4;  // memory word
  localparam logic [31:0] PW = 32'h1234_5678;  // memory word with positive bytes
  localparam logic [31:0] SW = 32'h1122_3344;  // store value
  localparam logic [31:0] OW = 32'h9988_7766;  // old register value

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  sz;
    logic        sg;
    logic        bm;
    logic [1:0]  off;
    logic [31:0] rd;
    logic [31:0] eld;
    logic [31:0] est;
    logic [3:0]  ebe;
    logic        emis;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 1'b0, 1'b0, 2'd1, MW, 32'h0000_00C3, 32'h0, 4'h0, 1'b0, 8'd1},
    '{2'd0, 2'd0, 1'b1, 1'b0, 2'd1, MW, 32'hFFFF_FFC3, 32'h0, 4'h0, 1'b0, 8'd3},
    '{2'd0, 2'd0, 1'b0, 1'b1, 2'd1, MW, 32'h0000_00B2, 32'h0, 4'h0, 1'b0, 8'd2},
    '{2'd0, 2'd0, 1'b1, 1'b1, 2'd3, MW, 32'hFFFF_FFD4, 32'h0, 4'h0, 1'b0, 8'd3},
    '{2'd0, 2'd1, 1'b0, 1'b0, 2'd2, MW, 32'h0000_A1B2, 32'h0, 4'h0, 1'b0, 8'd1},
    '{2'd0, 2'd1, 1'b1, 1'b0, 2'd2, MW, 32'hFFFF_A1B2, 32'h0, 4'h0, 1'b0, 8'd3},
    '{2'd0, 2'd1, 1'b1, 1'b1, 2'd2, MW, 32'hFFFF_C3D4, 32'h0, 4'h0, 1'b0, 8'd2},
    '{2'd0, 2'd1, 1'b0, 1'b1, 2'd0, MW, 32'h0000_A1B2, 32'h0, 4'h0, 1'b0, 8'd2},
    '{2'd0, 2'd2, 1'b0, 1'b0, 2'd0, MW, MW,            32'h0, 4'h0, 1'b0, 8'd1},
    '{2'd0, 2'd2, 1'b1, 1'b1, 2'd0, MW, MW,            32'h0, 4'h0, 1'b0, 8'd2},
    '{2'd0, 2'd1, 1'b1, 1'b0, 2'd0, PW, 32'h0000_5678, 32'h0, 4'h0, 1'b0, 8'd3},
    '{2'd0, 2'd0, 1'b1, 1'b0, 2'd0, PW, 32'h0000_0078, 32'h0, 4'h0, 1'b0, 8'd3},
    '{2'd0, 2'd1, 1'b0, 1'b0, 2'd1, MW, 32'h0,         32'h0, 4'h0, 1'b1, 8'd4},
    '{2'd0, 2'd2, 1'b0, 1'b1, 2'd2, MW, 32'h0,         32'h0, 4'h0, 1'b1, 8'd4},
    '{2'd1, 2'd2, 1'b0, 1'b0, 2'd3, MW, 32'h0,         32'h0, 4'h0, 1'b1, 8'd4},
    '{2'd1, 2'd1, 1'b0, 1'b1, 2'd3, MW, 32'h0,         32'h0, 4'h0, 1'b1, 8'd4},
    '{2'd1, 2'd0, 1'b0, 1'b0, 2'd3, MW, 32'h0, 32'h4400_0000, 4'h8, 1'b0, 8'd4},
    '{2'd1, 2'd0, 1'b0, 1'b0, 2'd2, MW, 32'h0, 32'h0044_0000, 4'h4, 1'b0, 8'd5},
    '{2'd1, 2'd0, 1'b0, 1'b1, 2'd2, MW, 32'h0, 32'h0000_4400, 4'h2, 1'b0, 8'd6},
    '{2'd1, 2'd1, 1'b0, 1'b0, 2'd2, MW, 32'h0, 32'h3344_0000, 4'hC, 1'b0, 8'd6},
    '{2'd1, 2'd1, 1'b0, 1'b1, 2'd2, MW, 32'h0, 32'h0000_3344, 4'h3, 1'b0, 8'd6},
    '{2'd1, 2'd1, 1'b0, 1'b1, 2'd0, MW, 32'h0, 32'h3344_0000, 4'hC, 1'b0, 8'd5},
    '{2'd1, 2'd2, 1'b0, 1'b1, 2'd0, MW, 32'h0, SW,            4'hF, 1'b0, 8'd5},
    '{2'd2, 2'd2, 1'b0, 1'b1, 2'd1, MW, 32'hB2C3_D466, 32'h0, 4'h0, 1'b0, 8'd7},
    '{2'd3, 2'd2, 1'b0, 1'b1, 2'd1, MW, 32'h9988_77A1, 32'h0, 4'h0, 1'b0, 8'd8},
    '{2'd2, 2'd2, 1'b0, 1'b0, 2'd1, MW, 32'h99A1_B2C3, 32'h0, 4'h0, 1'b0, 8'd7},
    '{2'd3, 2'd2, 1'b0, 1'b0, 2'd1, MW, 32'hD488_7766, 32'h0, 4'h0, 1'b0, 8'd8},
    '{2'd2, 2'd2, 1'b0, 1'b1, 2'd0, MW, MW,            32'h0, 4'h0, 1'b0, 8'd7},
    '{2'd3, 2'd2, 1'b0, 1'b0, 2'd0, MW, OW,            32'h0, 4'h0, 1'b0, 8'd8},
    '{2'd3, 2'd2, 1'b0, 1'b0, 2'd3, MW, 32'hB2C3_D466, 32'h0, 4'h0, 1'b0, 8'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [1:0]  req_op, req_size;
  logic        req_signed, req_big_endian;
  logic [1:0]  req_offset;
  logic [31:0] req_wdata, req_rdata, req_old;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_ld_data, rsp_st_data;
  logic [3:0]  rsp_be;
  logic        rsp_misalign;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  lsu_lane_align #(.LANES(4), .PIPE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_size(req_size), .req_signed(req_signed),
    .req_big_endian(req_big_endian), .req_offset(req_offset),
    .req_wdata(req_wdata), .req_rdata(req_rdata), .req_old(req_old),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ld_data(rsp_ld_data),
    .rsp_st_data(rsp_st_data), .rsp_be(rsp_be), .rsp_misalign(rsp_misalign)
  );

  function automatic string tag_of(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid      = 1'b1;
    req_op         = v.op;
    req_size       = v.sz;
    req_signed     = v.sg;
    req_big_endian = v.bm;
    req_offset     = v.off;
    req_wdata      = SW;
    req_rdata      = v.rd;
    req_old        = OW;
  endtask

  task automatic check_rsp(input vec_t v, input string tag);
    chk(tag, "rsp_valid", {31'b0, rsp_valid}, 32'h1);
    chk(tag, "ld_data",   rsp_ld_data, v.eld);
    chk(tag, "st_data",   rsp_st_data, v.est);
    chk(tag, "be",        {28'b0, rsp_be}, {28'b0, v.ebe});
    chk(tag, "misalign",  {31'b0, rsp_misalign}, {31'b0, v.emis});
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0;
    req_op = 2'd0; req_size = 2'd0; req_signed = 1'b0; req_big_endian = 1'b0;
    req_offset = 2'd0; req_wdata = '0; req_rdata = '0; req_old = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
    chk("R10", "req_ready in reset", {31'b0, req_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: one request per cycle, result checked one edge later.
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      rsp_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check_rsp(VECS[i], tag_of(int'(VECS[i].req)));
    end

    // R9: output drains, then is empty.
    @(posedge clk);
    @(negedge clk);
    chk("R9", "empty after drain", {31'b0, rsp_valid}, 32'h0);

    // R9: stall holds the waiting result and refuses new requests.
    drive(VECS[6]);
    rsp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9", "valid after accept", {31'b0, rsp_valid}, 32'h1);
    chk("R9", "ready while stalled", {31'b0, req_ready}, 32'h0);
    drive(VECS[19]);
    @(posedge clk);
    @(negedge clk);
    check_rsp(VECS[6], "R9");
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(VECS[19], "R9");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule